// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A small mode register holds the burst length and the wrap ordering. A column command presents a start column. From the following clock onward, the block drives one column address per cycle. It stops when the programmed length runs out, when a burst-stop command is sampled, or when another column command replaces the burst in progress.

Two orderings are supported. Sequential ordering counts upward and wraps inside the aligned block of the burst length. Interleaved ordering XORs the beat number into the low start bits. In full-page mode the block walks the whole 1024-column page in ascending order, wraps around, and runs until it is stopped or interrupted. The controller around the block reads the column address, a valid flag and a final-beat flag, and it uses them to sequence the data path. Data movement, bank and row handling and refresh belong to other blocks.

Top module: `sdram_col_gen`

## Requirements
- R1: While reset is asserted and after its release, with no command issued, `col_valid` and `col_last` are 0 and `col_addr` is 0.
- R2: A cycle with `cfg_we` high stores `cfg_len` and `cfg_ilv` for commands sampled in later cycles. Length codes: 3'b000 = 1 beat, 3'b001 = 2, 3'b010 = 4, 3'b011 = 8, 3'b111 = full page; any other code gives 1 beat. `cfg_ilv` = 1 selects interleaved ordering and 0 selects sequential. A burst keeps the mode it started with, even if the register is written while the burst runs.
- R3: When `col_cmd` is sampled high on a clock edge, the outputs after that edge show `col_valid` = 1 and `col_addr` equal to the sampled `col_start` (beat 0).
- R4: In sequential ordering with burst length BL, beat i addresses the aligned block base of the start column plus ((start mod BL) + i) mod BL.
- R5: In interleaved ordering with burst length BL, beat i addresses the aligned block base plus ((start mod BL) XOR i).
- R6: In full-page mode, beat i addresses (start + i) mod 1024 regardless of `cfg_ilv`, and the burst continues past 1024 beats until it is ended.
- R7: For lengths 1, 2, 4 and 8, `col_last` is 1 on exactly the final beat. After that beat `col_valid` returns to 0 unless a new command is sampled.
- R8: `col_last` is never 1 during a full-page burst.
- R9: A `stop_cmd` sampled during a burst ends it: after that edge `col_valid` is 0. If `col_cmd` is sampled at the same edge, the command takes priority.
- R10: A `col_cmd` sampled during a burst abandons that burst. The next cycle shows beat 0 of the new start column under the current mode.
- R11: Column commands on consecutive clocks are each honoured, so the address sequence shows each new start column one cycle after its command.
- R12: Whenever `col_valid` is 0, `col_addr` is 0 and `col_last` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_len | input | 3 | Burst length code |
| cfg_ilv | input | 1 | 1 = interleaved ordering, 0 = sequential |
| col_cmd | input | 1 | Column command: start a burst |
| col_start | input | 10 | Start column of the command |
| stop_cmd | input | 1 | Burst-stop command |
| col_addr | output | 10 | Column address of the current beat |
| col_valid | output | 1 | A beat is being presented |
| col_last | output | 1 | Current beat is the final one of a fixed-length burst |

## Verification
Every result appears one clock after the stimulus that causes it. A command, stop or mode write is sampled at a rising edge, and beat 0, the idle state or the new mode becomes visible right after that edge. Each further beat follows one edge later. The bench drives inputs shortly after a rising edge and samples the outputs at the same offset after the next edge, so the cycle it checks is always the one that the counted register stages make due. Expected addresses come from integer modulo and XOR arithmetic, swept over every length, both orderings and a range of start columns, including ones that sit on a page wrap.

// File: rtl/sdcg_pkg.sv
package sdcg_pkg;

  typedef struct packed {
    logic [2:0] len;
    logic       ilv;
  } sdcg_mode_t;

  localparam logic [2:0] LEN_1  = 3'b000;
  localparam logic [2:0] LEN_2  = 3'b001;
  localparam logic [2:0] LEN_4  = 3'b010;
  localparam logic [2:0] LEN_8  = 3'b011;
  localparam logic [2:0] LEN_FP = 3'b111;

  // Beat-index mask for fixed lengths (BL - 1); reserved codes act as one beat.
  function automatic logic [3:0] short_mask(input logic [2:0] len);
    case (len)
      LEN_2:   short_mask = 4'd1;
      LEN_4:   short_mask = 4'd3;
      LEN_8:   short_mask = 4'd7;
      default: short_mask = 4'd0;
    endcase
  endfunction

  function automatic logic is_full_page(input logic [2:0] len);
    is_full_page = (len == LEN_FP);
  endfunction

endpackage

// File: rtl/sdcg_mode_reg.sv
module sdcg_mode_reg
  import sdcg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  sdcg_mode_t mode_in,
  output sdcg_mode_t mode_q
);

  sdcg_mode_t mode_nxt;

  always_comb begin
    mode_nxt = mode_q;
    if (wr_en) mode_nxt = mode_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_nxt;
  end

endmodule

// File: rtl/sdcg_beat_ctr.sv
module sdcg_beat_ctr
  import sdcg_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd,
  input  logic [COL_W-1:0] start_in,
  input  logic             stop,
  input  sdcg_mode_t       mode_in,
  output logic             active,
  output logic [COL_W-1:0] start_q,
  output logic [COL_W-1:0] beat_q,
  output sdcg_mode_t       burst_mode,
  output logic             final_beat
);

  logic             act_q, act_nxt;
  logic [COL_W-1:0] start_nxt, beat_nxt;
  sdcg_mode_t       bm_q, bm_nxt;
  logic [COL_W-1:0] end_beat;

  assign end_beat   = COL_W'(short_mask(bm_q.len));
  assign final_beat = act_q && !is_full_page(bm_q.len) && (beat_q == end_beat);

  always_comb begin
    act_nxt   = act_q;
    start_nxt = start_q;
    beat_nxt  = beat_q;
    bm_nxt    = bm_q;
    if (cmd) begin
      act_nxt   = 1'b1;
      start_nxt = start_in;
      beat_nxt  = '0;
      bm_nxt    = mode_in;
    end else if (act_q) begin
      if (stop || final_beat) act_nxt  = 1'b0;
      else                    beat_nxt = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      start_q <= '0;
      beat_q  <= '0;
      bm_q    <= '0;
    end else begin
      act_q   <= act_nxt;
      start_q <= start_nxt;
      beat_q  <= beat_nxt;
      bm_q    <= bm_nxt;
    end
  end

  assign active     = act_q;
  assign burst_mode = bm_q;

endmodule

// File: rtl/sdcg_addr_map.sv
module sdcg_addr_map
  import sdcg_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             active,
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] beat,
  input  sdcg_mode_t       mode,
  output logic [COL_W-1:0] addr
);

  logic             fp;
  logic [COL_W-1:0] wrap_mask, seq_addr, ilv_addr;

  assign fp        = is_full_page(mode.len);
  assign wrap_mask = fp ? '1 : COL_W'(short_mask(mode.len));
  assign seq_addr  = (start & ~wrap_mask) | ((start + beat) & wrap_mask);
  assign ilv_addr  = (start & ~wrap_mask) | ((start ^ beat) & wrap_mask);

  always_comb begin
    if (!active)                addr = '0;
    else if (mode.ilv && !fp)   addr = ilv_addr;
    else                        addr = seq_addr;
  end

endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen
  import sdcg_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_len,
  input  logic             cfg_ilv,
  input  logic             col_cmd,
  input  logic [COL_W-1:0] col_start,
  input  logic             stop_cmd,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last
);

  sdcg_mode_t       mode_wr, mode_cur, mode_burst;
  logic             act;
  logic             fin;
  logic [COL_W-1:0] start_r, beat_r;

  assign mode_wr.len = cfg_len;
  assign mode_wr.ilv = cfg_ilv;

  sdcg_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_we),
    .mode_in (mode_wr),
    .mode_q  (mode_cur)
  );

  sdcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (col_cmd),
    .start_in   (col_start),
    .stop       (stop_cmd),
    .mode_in    (mode_cur),
    .active     (act),
    .start_q    (start_r),
    .beat_q     (beat_r),
    .burst_mode (mode_burst),
    .final_beat (fin)
  );

  sdcg_addr_map #(.COL_W(COL_W)) u_map (
    .active (act),
    .start  (start_r),
    .beat   (beat_r),
    .mode   (mode_burst),
    .addr   (col_addr)
  );

  assign col_valid = act;
  assign col_last  = fin;

endmodule

// File: rtl/sdram_col_gen_chk.sv
module sdram_col_gen_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             col_cmd,
  input logic [COL_W-1:0] col_start,
  input logic             stop_cmd,
  input logic [COL_W-1:0] col_addr,
  input logic             col_valid,
  input logic             col_last
);

  p_cmd_loads_r3: assert property (@(posedge clk) disable iff (!rst_n)
    col_cmd |=> (col_valid && col_addr == $past(col_start)));

  p_stop_ends_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_cmd && !col_cmd) |=> !col_valid);

  p_last_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (col_valid && col_last && !col_cmd) |=> !col_valid);

  p_idle_holds_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!col_valid && !col_cmd) |=> !col_valid);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid |-> (col_addr == '0 && !col_last));

endmodule

bind sdram_col_gen sdram_col_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .col_cmd   (col_cmd),
  .col_start (col_start),
  .stop_cmd  (stop_cmd),
  .col_addr  (col_addr),
  .col_valid (col_valid),
  .col_last  (col_last)
);

// File: tb/sdram_col_gen_tb.sv
module sdram_col_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_len = 3'b000;
  logic       cfg_ilv = 1'b0;
  logic       col_cmd = 1'b0;
  logic [9:0] col_start = '0;
  logic       stop_cmd = 1'b0;
  logic [9:0] col_addr;
  logic       col_valid;
  logic       col_last;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sdram_col_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_len(cfg_len),
    .cfg_ilv(cfg_ilv), .col_cmd(col_cmd), .col_start(col_start),
    .stop_cmd(stop_cmd), .col_addr(col_addr), .col_valid(col_valid),
    .col_last(col_last)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(string req, bit v, bit l, int a);
    n_chk++;
    if (col_valid !== v || col_last !== l || col_addr !== 10'(a)) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b last=%0b addr=%0d, expected valid=%0b last=%0b addr=%0d",
               req, col_valid, col_last, col_addr, v, l, a);
    end
  endtask

  task automatic set_mode(logic [2:0] code, bit ilv);
    cfg_len = code; cfg_ilv = ilv; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic issue(int start);
    col_start = 10'(start); col_cmd = 1'b1;
    tick();
    col_cmd = 1'b0;
  endtask

  // bl == 0 stands for full page
  function automatic int model(int start, int bl, bit ilv, int i);
    int base, off;
    if (bl == 0) return (start + i) % 1024;
    off  = start % bl;
    base = start - off;
    if (ilv) return base + (off ^ i);
    return base + ((off + i) % bl);
  endfunction

  function automatic logic [2:0] code_of(int bl);
    case (bl)
      2: return 3'b001;
      4: return 3'b010;
      8: return 3'b011;
      default: return 3'b000;
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    if (!done) begin
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    expect_out("R1 in reset", 0, 0, 0);
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick();
    expect_out("R1 after reset", 0, 0, 0);

    // R4 R5 R7 R12: sweep lengths, orderings and starts
    for (int b = 0; b < 4; b++) begin
      for (int o = 0; o < 2; o++) begin
        set_mode(code_of(1 << b), o[0]);
        for (int s = 0; s < 24; s++) begin
          int st;
          st = (s < 16) ? s : 1000 + s;
          issue(st);
          for (int i = 0; i < (1 << b); i++) begin
            expect_out(o ? "R5 interleaved beat" : "R4 sequential beat", 1,
                       i == (1 << b) - 1, model(st, 1 << b, o[0], i));
            tick();
          end
          expect_out("R7 R12 idle after final beat", 0, 0, 0);
        end
      end
    end

    // R6 R8: full page wraps, order ignored, never last, runs past 1024
    set_mode(3'b111, 1'b1);
    issue(1020);
    for (int i = 0; i < 1030; i++) begin
      expect_out("R6 R8 full page beat", 1, 0, model(1020, 0, 0, i));
      tick();
    end
    stop_cmd = 1'b1;
    tick();
    stop_cmd = 1'b0;
    expect_out("R9 stop ends full page", 0, 0, 0);

    // R9: stop inside a fixed burst, and command beating a stop
    set_mode(3'b011, 1'b0);
    issue(20);
    expect_out("R3 beat 0", 1, 0, 20);
    tick();
    expect_out("R4 beat 1", 1, 0, 21);
    stop_cmd = 1'b1;
    tick();
    stop_cmd = 1'b0;
    expect_out("R9 stop mid burst", 0, 0, 0);
    issue(50);
    stop_cmd = 1'b1; col_cmd = 1'b1; col_start = 10'd70;
    tick();
    stop_cmd = 1'b0; col_cmd = 1'b0;
    expect_out("R9 command wins over stop", 1, 0, 70);
    tick();
    expect_out("R9 command wins over stop beat1", 1, 0, 71);

    // R10: interrupt mid burst
    issue(5);
    tick(); tick();
    expect_out("R10 before interrupt", 1, 0, 7);
    issue(44);
    for (int i = 0; i < 8; i++) begin
      expect_out("R10 restarted burst", 1, i == 7, model(44, 8, 0, i));
      tick();
    end
    expect_out("R10 idle after restart", 0, 0, 0);

    // R11: back-to-back commands
    set_mode(3'b010, 1'b1);
    col_cmd = 1'b1;
    for (int k = 0; k < 5; k++) begin
      col_start = 10'(100 * k + 3);
      tick();
      expect_out("R11 back-to-back start", 1, 0, 100 * k + 3);
    end
    col_cmd = 1'b0;
    for (int i = 1; i < 4; i++) begin
      tick();
      expect_out("R11 tail burst", 1, i == 3, model(403, 4, 1, i));
    end
    tick();
    expect_out("R11 idle", 0, 0, 0);

    // R2: mode write mid burst does not disturb it; reserved code = 1 beat
    set_mode(3'b011, 1'b0);
    issue(3);
    expect_out("R2 beat 0", 1, 0, 3);
    cfg_len = 3'b000; cfg_ilv = 1'b1; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
    for (int i = 1; i < 8; i++) begin
      expect_out("R2 burst keeps its mode", 1, i == 7, model(3, 8, 0, i));
      tick();
    end
    expect_out("R2 idle", 0, 0, 0);
    issue(9);
    expect_out("R2 new mode single beat", 1, 1, 9);
    tick();
    expect_out("R2 new mode idle", 0, 0, 0);
    set_mode(3'b101, 1'b0);
    issue(77);
    expect_out("R2 reserved code one beat", 1, 1, 77);
    tick();
    expect_out("R2 reserved code idle", 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule